// File: doc/BRIEF.md
# Watchdog Timer with Prescaler Select

This block is an 8-bit watchdog. It counts ticks of a chosen count clock. If software does not reload it before it passes 0xFF, it raises an internal reset pulse for the rest of the chip. A free-running prescaler on the system clock supplies eight power-of-two taps, from divide-by-64 up to divide-by-8192. A slow oscillator input, independent of the system clock, can be selected in place of the taps. That input is synchronized and edge-detected, so each of its rising edges becomes a single-cycle tick.

Software controls the block through four write-only registers behind one write strobe. These set the clock source, preload the counter and turn the timer on or off. The preload fixes the time to overflow. The timer comes out of power-on reset already running, so it guards the system before any software has executed. Turning it off takes a keyed two-write sequence. A sticky flag records that a watchdog reset has happened. That flag is not cleared by the pulse the block itself produces.

Top module: `watchdog_top`

## Requirements
- R1: While and just after power-on reset (`rstN` low), `cntOut` is 0x00, `selOut` is 7, `enOut` is 1, `ovfFlag` is 0 and `wdRstOut` is 0.
- R2: With no write after reset, the counter first reaches 0x01 on the 8192nd rising clock edge after reset is released. This is the divide-by-8192 tap.
- R3: A write to address 0 with a value from 0 to 7 selects the system clock divided by 2^(6+value). After a counter write, the counter increments exactly every 2^(6+value) clock edges.
- R4: Value 8 at address 0 selects the oscillator input `oscIn`. The counter increments once for each rising edge of `oscIn`, on the third clock edge that samples it high. Holding `oscIn` high or low adds nothing further, and the prescaler taps are then ignored.
- R5: A write to address 0 with any byte above 8 leaves the clock select unchanged.
- R6: A tick that finds the counter at 0xFF wraps it to 0x00. It also drives `wdRstOut` high for exactly 4 clock cycles. During those cycles counting is held and the prescaler is cleared. `enOut` and the select stay as they were, and the next increment comes 2^(6+select) edges after the pulse ends.
- R7: Writing value V to address 1 gives an overflow after exactly 256−V ticks. This spans 1 tick for 0xFF up to 256 ticks for 0x00.
- R8: A write to address 1 loads the written byte on the next edge and restarts the prescaler phase. When it coincides with a tick, the written value wins and no increment or overflow happens.
- R9: The counter is disabled only by writing 0x5A to address 2 and then, as the very next write, 0x00 to address 2. Any other sequence leaves `enOut` at 1. While disabled, the counter holds its value. Writing 0x01 to address 2 re-enables it, and the next increment comes 2^(6+select) edges later.
- R10: `ovfFlag` goes to 1 on every overflow and stays there through the watchdog pulse. Only a write to address 3 with bit 0 set, or power-on reset, clears it; a write with bit 0 clear does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 2 | Register address: 0 select, 1 counter, 2 enable/key, 3 flag clear |
| wrData | input | 8 | Write data |
| oscIn | input | 1 | Dedicated slow oscillator, asynchronous to `clk` |
| wdRstOut | output | 1 | Internal reset pulse, high for 4 cycles after overflow |
| cntOut | output | 8 | Current counter value |
| selOut | output | 4 | Current clock select code |
| enOut | output | 1 | Timer enable |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
A counter write takes effect on the edge that samples it. After that, a tap of divisor D produces its first increment D edges later. The bench therefore checks the old value after D−1 edges and the new one after D. An overflow shows on `wdRstOut` and `ovfFlag` on the same edge that wraps the counter. The pulse is checked high after 1 and 4 edges and low after the 5th. An oscillator rise is checked unchanged two edges on and incremented on the third. All samples are taken on the falling clock edge, after a known count of rising edges since the last write, so each check lands in the one cycle its result is due.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  localparam int CNT_W = 8;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    ADDR_SEL  = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_EN   = 2'd2,
    ADDR_STAT = 2'd3
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic [CNT_W-1:0] loadVal;
    logic             run;
    logic [SEL_W-1:0] sel;
  } dpCtl_t;

endpackage

// File: rtl/wdog_dp.sv
`timescale 1ns/1ps
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int TAP_NUM     = 8,
  parameter int TAP_BASE    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             oscIn,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  localparam int PRE_W  = TAP_BASE + TAP_NUM - 1;
  localparam int TAP_IW = (TAP_NUM > 1) ? $clog2(TAP_NUM) : 1;

  logic [PRE_W-1:0]   pre;
  logic [TAP_NUM-1:0] tapHit;
  logic [SYNC_STAGES:0] oscPipe;
  logic oscTick;
  logic tick;
  logic fire;

  // shared prescaler, cleared on reload or while not running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     pre <= '0;
    else if (ctl.load || !ctl.run) pre <= '0;
    else                           pre <= pre + 1'b1;
  end

  // tap g fires on the last phase of a 2^(TAP_BASE+g) period
  for (genvar g = 0; g < TAP_NUM; g++) begin : g_tap
    assign tapHit[g] = &pre[TAP_BASE+g-1:0];
  end

  // oscillator synchronizer plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oscPipe <= '0;
    else       oscPipe <= {oscPipe[SYNC_STAGES-1:0], oscIn};
  end
  assign oscTick = oscPipe[SYNC_STAGES-1] & ~oscPipe[SYNC_STAGES];

  always_comb begin
    if (ctl.sel < SEL_W'(TAP_NUM)) tick = tapHit[ctl.sel[TAP_IW-1:0]];
    else                           tick = oscTick;
  end

  assign fire = ctl.run & tick;
  assign ovf  = fire & (cnt == '1) & ~ctl.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (ctl.load) cnt <= ctl.loadVal;
    else if (fire)     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdog_ctrl.sv
`timescale 1ns/1ps
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int              TAP_NUM   = 8,
  parameter int              PULSE_LEN = 4,
  parameter int              SEL_RESET = 7,
  parameter logic [CNT_W-1:0] KEY      = 8'h5A,
  parameter logic [CNT_W-1:0] DIS_CMD  = 8'h00,
  parameter logic [CNT_W-1:0] EN_CMD   = 8'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             ovf,
  output dpCtl_t           ctl,
  output logic [SEL_W-1:0] selOut,
  output logic             enOut,
  output logic             flagOut,
  output logic             wdRst
);

  localparam int PCNT_W = $clog2(PULSE_LEN + 1);

  logic [SEL_W-1:0]  selReg;
  logic              enReg;
  logic              armed;
  logic              flag;
  logic [PCNT_W-1:0] pulseCnt;

  logic selWr, cntWr, enWr, statWr, selOk;

  assign selWr  = wrEn && (wrAddr == ADDR_SEL);
  assign cntWr  = wrEn && (wrAddr == ADDR_CNT);
  assign enWr   = wrEn && (wrAddr == ADDR_EN);
  assign statWr = wrEn && (wrAddr == ADDR_STAT);
  assign selOk  = (wrData[CNT_W-1:SEL_W] == '0) &&
                  (wrData[SEL_W-1:0] <= SEL_W'(TAP_NUM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               selReg <= SEL_W'(SEL_RESET);
    else if (selWr && selOk) selReg <= wrData[SEL_W-1:0];
  end

  // key must be the write just before the disable command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     armed <= 1'b0;
    else if (wrEn) armed <= enWr && (wrData == KEY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                enReg <= 1'b1;
    else if (enWr && armed && wrData == DIS_CMD) enReg <= 1'b0;
    else if (enWr && wrData == EN_CMD)        enReg <= 1'b1;
  end

  // sticky flag, set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    flag <= 1'b0;
    else if (ovf)                 flag <= 1'b1;
    else if (statWr && wrData[0]) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseCnt <= '0;
    else if (ovf)             pulseCnt <= PCNT_W'(PULSE_LEN);
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
  end

  always_comb begin
    ctl.load    = cntWr;
    ctl.loadVal = wrData;
    ctl.run     = enReg && (pulseCnt == '0);
    ctl.sel     = selReg;
  end

  assign selOut  = selReg;
  assign enOut   = enReg;
  assign flagOut = flag;
  assign wdRst   = (pulseCnt != '0);

endmodule

// File: rtl/watchdog_top.sv
`timescale 1ns/1ps
module watchdog_top
  import wdog_pkg::*;
#(
  parameter int              TAP_NUM     = 8,
  parameter int              TAP_BASE    = 6,
  parameter int              SYNC_STAGES = 2,
  parameter int              PULSE_LEN   = 4,
  parameter int              SEL_RESET   = 7,
  parameter logic [CNT_W-1:0] KEY        = 8'h5A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic             oscIn,
  output logic             wdRstOut,
  output logic [7:0]       cntOut,
  output logic [3:0]       selOut,
  output logic             enOut,
  output logic             ovfFlag
);

  dpCtl_t ctl;
  logic   ovf;

  wdog_ctrl #(
    .TAP_NUM  (TAP_NUM),
    .PULSE_LEN(PULSE_LEN),
    .SEL_RESET(SEL_RESET),
    .KEY      (KEY)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .ovf    (ovf),
    .ctl    (ctl),
    .selOut (selOut),
    .enOut  (enOut),
    .flagOut(ovfFlag),
    .wdRst  (wdRstOut)
  );

  wdog_dp #(
    .TAP_NUM    (TAP_NUM),
    .TAP_BASE   (TAP_BASE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .oscIn(oscIn),
    .cnt  (cntOut),
    .ovf  (ovf)
  );

endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk #(
  parameter int         TAP_NUM   = 8,
  parameter int         PULSE_LEN = 4,
  parameter logic [7:0] KEY       = 8'h5A
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic [7:0] wrData,
  input logic       oscIn,
  input logic       wdRstOut,
  input logic [7:0] cntOut,
  input logic [3:0] selOut,
  input logic       enOut,
  input logic       ovfFlag
);

  logic keyPrev;
  logic prevRst;
  int   runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     keyPrev <= 1'b0;
    else if (wrEn) keyPrev <= (wrAddr == 2'd2) && (wrData == KEY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRst <= 1'b0;
      runLen  <= 0;
    end else begin
      prevRst <= wdRstOut;
      if (wdRstOut && !prevRst) runLen <= 1;
      else if (wdRstOut)        runLen <= runLen + 1;
    end
  end

  // R6: pulse lasts exactly PULSE_LEN cycles
  a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    (!wdRstOut && prevRst) |-> (runLen == PULSE_LEN));

  // R6: counter is at zero when the pulse starts
  a_r6_cnt_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRstOut) |-> (cntOut == 8'h00));

  // R10: flag is up whenever a pulse starts
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRstOut) |-> ovfFlag);

  // R8: counter write loads on the next edge
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd1) |=> (cntOut == $past(wrData)));

  // R7: without a load the counter only steps by one
  a_r7_step_one: assert property (@(posedge clk) disable iff (!rstN)
    ((cntOut != $past(cntOut)) && !$past(wrEn && wrAddr == 2'd1))
      |-> (cntOut == $past(cntOut) + 8'd1));

  // R9: enable drops only after key then disable command
  a_r9_keyed_off: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enOut) |-> $past(keyPrev && wrEn && wrAddr == 2'd2 && wrData == 8'h00));

  // R5: select never holds an undefined code
  a_r5_sel_range: assert property (@(posedge clk) disable iff (!rstN)
    selOut <= 4'(TAP_NUM));

endmodule

bind watchdog_top wdog_chk #(
  .TAP_NUM  (TAP_NUM),
  .PULSE_LEN(PULSE_LEN),
  .KEY      (KEY)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .oscIn   (oscIn),
  .wdRstOut(wdRstOut),
  .cntOut  (cntOut),
  .selOut  (selOut),
  .enOut   (enOut),
  .ovfFlag (ovfFlag)
);

// File: tb/sim_watchdog_top.sv
`timescale 1ns/1ps
module sim_watchdog_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic       oscIn = 1'b0;
  logic       wdRstOut;
  logic [7:0] cntOut;
  logic [3:0] selOut;
  logic       enOut;
  logic       ovfFlag;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  watchdog_top u0 (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .oscIn   (oscIn),
    .wdRstOut(wdRstOut),
    .cntOut  (cntOut),
    .selOut  (selOut),
    .enOut   (enOut),
    .ovfFlag (ovfFlag)
  );

  function automatic int periodOf(input int code);
    return 1 << (6 + code);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic waitEdges(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cnt", cntOut, 8'h00);
    check("R1 sel", selOut, 7);
    check("R1 en", enOut, 1);
    check("R1 flag", ovfFlag, 0);
    check("R1 rst", wdRstOut, 0);
    rstN = 1'b1;

    // R2 runs on the divide-by-8192 tap without any write
    waitEdges(8191);
    check("R2 before tick", cntOut, 8'h00);
    waitEdges(1);
    check("R2 first tick", cntOut, 8'h01);

    // R3 tap periods
    for (int code = 0; code < 6; code++) begin
      wr(2'd0, 8'(code));
      check("R3 sel", selOut, code);
      wr(2'd1, 8'h20);
      waitEdges(periodOf(code) - 1);
      check("R3 hold", cntOut, 8'h20);
      waitEdges(1);
      check("R3 step", cntOut, 8'h21);
    end

    // R8 write colliding with a tick
    wr(2'd0, 8'd0);
    wr(2'd1, 8'h40);
    waitEdges(63);
    wr(2'd1, 8'h80);
    check("R8 write wins", cntOut, 8'h80);
    waitEdges(63);
    check("R8 restart hold", cntOut, 8'h80);
    waitEdges(1);
    check("R8 restart step", cntOut, 8'h81);

    // R6 / R7 single-tick overflow
    wr(2'd1, 8'hFF);
    waitEdges(63);
    check("R7 pre ovf cnt", cntOut, 8'hFF);
    check("R6 pre ovf rst", wdRstOut, 0);
    waitEdges(1);
    check("R6 rst high", wdRstOut, 1);
    check("R6 cnt wrap", cntOut, 8'h00);
    check("R10 flag set", ovfFlag, 1);
    waitEdges(3);
    check("R6 rst 4th", wdRstOut, 1);
    check("R6 cnt held", cntOut, 8'h00);
    waitEdges(1);
    check("R6 rst low", wdRstOut, 0);
    check("R6 en kept", enOut, 1);
    check("R6 sel kept", selOut, 0);
    waitEdges(63);
    check("R6 resume hold", cntOut, 8'h00);
    waitEdges(1);
    check("R6 resume step", cntOut, 8'h01);

    // R10 flag survives; write 0 ignored, write 1 clears
    check("R10 flag after pulse", ovfFlag, 1);
    wr(2'd3, 8'h00);
    check("R10 no clear", ovfFlag, 1);
    wr(2'd3, 8'h01);
    check("R10 cleared", ovfFlag, 0);

    // R7 longest period: 256 ticks
    wr(2'd1, 8'h00);
    waitEdges(256 * 64 - 1);
    check("R7 long pre", wdRstOut, 0);
    check("R7 long cnt", cntOut, 8'hFF);
    waitEdges(1);
    check("R7 long ovf", wdRstOut, 1);
    waitEdges(4);
    wr(2'd3, 8'h01);

    // R5 invalid select codes
    wr(2'd0, 8'd9);
    check("R5 code 9", selOut, 0);
    wr(2'd0, 8'd15);
    check("R5 code 15", selOut, 0);
    wr(2'd0, 8'h10);
    check("R5 code 0x10", selOut, 0);

    // R4 oscillator source
    wr(2'd0, 8'd8);
    check("R4 sel osc", selOut, 8);
    wr(2'd1, 8'h10);
    oscIn = 1'b1;
    waitEdges(2);
    check("R4 latency hold", cntOut, 8'h10);
    waitEdges(1);
    check("R4 latency step", cntOut, 8'h11);
    waitEdges(40);
    check("R4 level no tick", cntOut, 8'h11);
    oscIn = 1'b0;
    waitEdges(10);
    for (int k = 0; k < 2; k++) begin
      oscIn = 1'b1; waitEdges(5);
      oscIn = 1'b0; waitEdges(5);
    end
    check("R4 two edges", cntOut, 8'h13);
    waitEdges(200);
    check("R4 taps ignored", cntOut, 8'h13);

    // R9 keyed disable
    wr(2'd0, 8'd0);
    wr(2'd2, 8'h00);
    check("R9 no key", enOut, 1);
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'h30);
    wr(2'd2, 8'h00);
    check("R9 broken seq", enOut, 1);
    wr(2'd1, 8'h30);
    wr(2'd2, 8'h5A);
    wr(2'd2, 8'h00);
    check("R9 disabled", enOut, 0);
    waitEdges(300);
    check("R9 frozen", cntOut, 8'h30);
    wr(2'd2, 8'h01);
    check("R9 reenabled", enOut, 1);
    waitEdges(63);
    check("R9 resume hold", cntOut, 8'h30);
    waitEdges(1);
    check("R9 resume step", cntOut, 8'h31);

    // R3 / R8 random loads on the faster taps
    for (int i = 0; i < 8; i++) begin
      int code;
      int val;
      code = int'($urandom_range(2, 0));
      val  = int'($urandom_range(254, 0));
      wr(2'd0, 8'(code));
      wr(2'd1, 8'(val));
      check("R8 rand load", cntOut, val);
      waitEdges(periodOf(code) - 1);
      check("R3 rand hold", cntOut, val);
      waitEdges(1);
      check("R3 rand step", cntOut, (val + 1) & 8'hFF);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule